// File: doc/BRIEF.md
# Audio Descriptor Ring Walker

This block moves one audio DMA channel through a ring of buffer descriptors kept in a small local table. Each descriptor holds only a sample count. Software loads the table through a write port and picks a channel mode (2, 4 or 6 interleaved channels). It then pulses `start` with a start index. From there the walker goes forward through the ring, one descriptor at a time. For each sample still owed in the current descriptor it raises a request strobe, and it stops once the descriptor at the programmed last valid index has been used up.

Descriptors that hold no samples are passed over on the way, but not in the first position or at the last valid index. Every descriptor that holds samples must contain whole frames for the active mode. A descriptor that breaks either rule halts the walker. It then raises a sticky error that only a channel reset clears.

When the walker reaches the end of the list it raises a status flag and waits. This is not a fault. If software then moves the last valid index forward, the walker continues from where it stopped.

Top module: `bdl_walker`

## Requirements
- R1: After `rst_n` low or a cycle with `chan_rst` high, the walker is idle: `busy`, `smp_req`, `at_end` and `frm_err` are 0, `cur_idx` is 0 and `remain` is 0.
- R2: A `start` pulse while idle loads `cur_idx` from `start_idx`. Descriptors are then visited in ascending index order, and the 5-bit index wraps from 31 to 0.
- R3: During a transfer, `smp_req` is high exactly while `remain` is non-zero. Each cycle with `smp_req` and `smp_take` both high lowers `remain` by one. `remain` holds when `smp_take` is low.
- R4: A descriptor with a count of 0 that is neither the first one visited since `start` nor at index `lvi` is skipped in one cycle, without any request.
- R5: A count of 0 in the first descriptor visited, or in the descriptor at index `lvi`, is a framing error.
- R6: A non-zero count must be a multiple of the channel count: mode 00 = 2, 01 = 4, 10 = 6, and 11 is treated as 2. Any other count, including 1 and all odd counts, is a framing error.
- R7: A framing error halts the walker. `frm_err` stays at 1, `cur_idx` holds the offending index, `smp_req` stays low and `start` is ignored, until `chan_rst`.
- R8: After the last sample of the descriptor at `lvi`, `at_end` goes to 1 and `smp_req` stays low. `frm_err` is not raised.
- R9: While `at_end` is 1, setting `lvi` to a different index makes the walker step to `cur_idx`+1 and clear `at_end`, and the transfer continues.
- R10: `start` has no effect unless the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_rst | input | 1 | Synchronous channel reset; also clears the error |
| mode | input | 2 | Channel mode: 00 = 2, 01 = 4, 10 = 6, 11 = 2 |
| start | input | 1 | Start pulse (used only when idle) |
| start_idx | input | 5 | First descriptor index |
| lvi | input | 5 | Last valid index; may change while running |
| tbl_we | input | 1 | Descriptor table write enable |
| tbl_addr | input | 5 | Descriptor table write index |
| tbl_wdata | input | 16 | Sample count to write |
| smp_take | input | 1 | Consumer accepts the requested sample |
| smp_req | output | 1 | Sample request strobe |
| cur_idx | output | 5 | Current descriptor index |
| remain | output | 16 | Samples left in the current descriptor |
| busy | output | 1 | Walker is not idle |
| at_end | output | 1 | Finished the descriptor at the last valid index |
| frm_err | output | 1 | Sticky framing error |

## Verification
The assertions check the rules that hold on every cycle:
- a request only appears while samples are left;
- each accepted sample lowers the count by exactly one, and the count holds when nothing is taken;
- a skip moves the index by one;
- a zero count at either edge of the list always leads to the error;
- the error and the end flag keep requests off, and the error is sticky.

Other behaviour can only be shown by the bench's scenarios:
- the total number of samples across a whole list;
- which index the walker reports when it halts on an error;
- wrapping from index 31 to 0;
- each channel mode's frame rule;
- resuming after the last valid index is raised;
- ignoring `start` while busy or halted.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_LOAD,
    WS_XFER,
    WS_END,
    WS_HALT
  } walk_st_e;

  // Number of interleaved channels for a mode code.
  function automatic int unsigned chans_of(input logic [1:0] mode);
    case (mode)
      2'b01:   return 4;
      2'b10:   return 6;
      default: return 2;
    endcase
  endfunction

  // True when a count is a whole number of frames for the mode.
  function automatic logic frames_whole(input logic [31:0] cnt, input logic [1:0] mode);
    return (cnt % chans_of(mode)) == 0;
  endfunction

endpackage

// File: rtl/bdl_table.sv
module bdl_table #(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [CNT_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CNT_W-1:0] cnt_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q[g] <= '0;
      else if (we && (waddr == IDX_W'(g)))
        cnt_q[g] <= wdata;
    end
  end

  assign rdata = cnt_q[raddr];

endmodule

// File: rtl/bdl_frame_rule.sv
module bdl_frame_rule #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       mode,
  input  logic             is_first,
  input  logic             is_last,
  output logic             skip,
  output logic             bad
);
  import bdl_pkg::*;

  logic empty;
  logic whole;

  assign empty = (cnt == '0);
  assign whole = frames_whole(32'(cnt), mode);
  assign skip  = empty && !is_first && !is_last;
  assign bad   = empty ? (is_first || is_last) : !whole;

endmodule

// File: rtl/bdl_walk_fsm.sv
module bdl_walk_fsm #(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_rst,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] lvi,
  input  logic             take,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             skip_in,
  input  logic             bad_in,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] cur_idx,
  output logic [CNT_W-1:0] remain,
  output logic             smp_req,
  output logic             busy,
  output logic             at_end,
  output logic             frm_err
);
  import bdl_pkg::*;

  walk_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] rem_q;
  logic             first_q;

  // Named internal events
  logic ev_skip, ev_fault, ev_accept, ev_last;

  assign ev_fault  = (st_q == WS_LOAD) && bad_in;
  assign ev_skip   = (st_q == WS_LOAD) && !bad_in && skip_in;
  assign ev_accept = (st_q == WS_XFER) && take;
  assign ev_last   = ev_accept && (rem_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
    end else if (chan_rst) begin
      st_q    <= WS_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
    end else begin
      case (st_q)
        WS_IDLE: if (start) begin
          idx_q   <= start_idx;
          first_q <= 1'b1;
          st_q    <= WS_LOAD;
        end
        WS_LOAD: begin
          if (bad_in)       st_q  <= WS_HALT;
          else if (skip_in) idx_q <= idx_q + 1'b1;
          else begin
            rem_q   <= cnt_in;
            first_q <= 1'b0;
            st_q    <= WS_XFER;
          end
        end
        WS_XFER: if (take) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            if (idx_q == lvi) st_q <= WS_END;
            else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= WS_LOAD;
            end
          end
        end
        WS_END: if (lvi != idx_q) begin
          idx_q <= idx_q + 1'b1;
          st_q  <= WS_LOAD;
        end
        default: ;  // WS_HALT holds until channel reset
      endcase
    end
  end

  assign first_o = first_q;
  assign last_o  = (idx_q == lvi);
  assign cur_idx = idx_q;
  assign remain  = rem_q;
  assign smp_req = (st_q == WS_XFER);
  assign busy    = (st_q != WS_IDLE);
  assign at_end  = (st_q == WS_END);
  assign frm_err = (st_q == WS_HALT);

  // R1: channel reset returns to a clean idle state
  p_chan_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (!busy && !frm_err && remain == '0));

  // R3: a request only with samples left
  p_req_has_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> (remain != '0));

  // R3: every accepted sample lowers the count by one
  p_take_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !chan_rst) |=> (remain == $past(remain) - 1'b1));

  // R3: the count holds when not transferring and not loading
  p_count_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_req && st_q != WS_LOAD && !chan_rst) |=> $stable(remain));

  // R4: a skip advances the index by exactly one
  p_skip_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_skip && !chan_rst) |=> (cur_idx == $past(cur_idx) + 1'b1));

  // R5: zero count at either edge of the list leads to the error
  p_zero_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_LOAD && cnt_in == '0 && (first_q || idx_q == lvi) && !chan_rst)
      |=> frm_err);

  // R7: the error is sticky and freezes the index
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err && !chan_rst) |=> (frm_err && $stable(cur_idx)));

  // R7/R8: no requests once halted or finished
  p_quiet_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end || frm_err) |-> !smp_req);

  // R8: end of list is not reported as a fault
  p_end_no_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_last && idx_q == lvi && !chan_rst) |=> (at_end && !frm_err));

endmodule

// File: rtl/bdl_walker.sv
module bdl_walker #(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_rst,
  input  logic [1:0]       mode,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] lvi,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [CNT_W-1:0] tbl_wdata,
  input  logic             smp_take,
  output logic             smp_req,
  output logic [IDX_W-1:0] cur_idx,
  output logic [CNT_W-1:0] remain,
  output logic             busy,
  output logic             at_end,
  output logic             frm_err
);
  logic [CNT_W-1:0] rd_cnt;
  logic             is_first, is_last, skip_w, bad_w;

  bdl_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (cur_idx),
    .rdata (rd_cnt)
  );

  bdl_frame_rule #(.CNT_W(CNT_W)) u_rule (
    .cnt      (rd_cnt),
    .mode     (mode),
    .is_first (is_first),
    .is_last  (is_last),
    .skip     (skip_w),
    .bad      (bad_w)
  );

  bdl_walk_fsm #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_rst  (chan_rst),
    .start     (start),
    .start_idx (start_idx),
    .lvi       (lvi),
    .take      (smp_take),
    .cnt_in    (rd_cnt),
    .skip_in   (skip_w),
    .bad_in    (bad_w),
    .first_o   (is_first),
    .last_o    (is_last),
    .cur_idx   (cur_idx),
    .remain    (remain),
    .smp_req   (smp_req),
    .busy      (busy),
    .at_end    (at_end),
    .frm_err   (frm_err)
  );

endmodule

// File: tb/tb_bdl_walker.sv
module tb_bdl_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_rst = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        start = 1'b0;
  logic [4:0]  start_idx = '0;
  logic [4:0]  lvi = '0;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic        smp_take = 1'b0;
  logic        smp_req, busy, at_end, frm_err;
  logic [4:0]  cur_idx;
  logic [15:0] remain;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  bdl_walker dut (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .mode(mode),
    .start(start), .start_idx(start_idx), .lvi(lvi),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .smp_take(smp_take), .smp_req(smp_req), .cur_idx(cur_idx),
    .remain(remain), .busy(busy), .at_end(at_end), .frm_err(frm_err)
  );

  // {mode, start index, four counts}; lvi is start + 3
  localparam int NV = 11;
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 5'd4,  16'd2, 16'd4,  16'd6, 16'd8},
    {2'd1, 5'd10, 16'd4, 16'd0,  16'd0, 16'd8},
    {2'd2, 5'd20, 16'd6, 16'd12, 16'd0, 16'd18},
    {2'd0, 5'd30, 16'd2, 16'd2,  16'd2, 16'd2},
    {2'd0, 5'd0,  16'd0, 16'd2,  16'd2, 16'd2},
    {2'd1, 5'd5,  16'd4, 16'd4,  16'd0, 16'd0},
    {2'd0, 5'd7,  16'd2, 16'd3,  16'd2, 16'd2},
    {2'd0, 5'd12, 16'd1, 16'd2,  16'd2, 16'd2},
    {2'd2, 5'd16, 16'd6, 16'd8,  16'd6, 16'd6},
    {2'd3, 5'd24, 16'd2, 16'd6,  16'd4, 16'd2},
    {2'd1, 5'd2,  16'd4, 16'd6,  16'd4, 16'd4}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_chan_rst();
    @(negedge clk); chan_rst = 1'b1;
    @(negedge clk); chan_rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic pulse_start(input logic [4:0] s);
    @(negedge clk); start = 1'b1; start_idx = s;
    @(negedge clk); start = 1'b0;
  endtask

  // Counts requests with smp_take held high until end or error
  task automatic drain(output int n);
    n = 0;
    for (int t = 0; t < 400; t++) begin
      if (at_end || frm_err) break;
      if (smp_req) n++;
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input int v);
    logic [70:0] e;
    logic [15:0] c [4];
    logic [4:0]  s;
    int ch, exp_n, got_n, exp_idx;
    logic exp_err, stop;
    e = VEC[v];
    s = e[68:64];
    c[0] = e[63:48]; c[1] = e[47:32]; c[2] = e[31:16]; c[3] = e[15:0];
    ch = (e[70:69] == 2'd1) ? 4 : (e[70:69] == 2'd2) ? 6 : 2;
    exp_n = 0; exp_err = 1'b0; stop = 1'b0; exp_idx = int'(5'(s + 5'd3));
    for (int k = 0; k < 4; k++) begin
      if (!stop) begin
        if (c[k] == 0) begin
          if (k == 0 || k == 3) begin
            exp_err = 1'b1; stop = 1'b1; exp_idx = int'(5'(s + 5'(k)));
          end
        end else if ((int'(c[k]) % ch) != 0) begin
          exp_err = 1'b1; stop = 1'b1; exp_idx = int'(5'(s + 5'(k)));
        end else exp_n += int'(c[k]);
      end
    end
    pulse_chan_rst();
    for (int k = 0; k < 4; k++) wr(5'(s + 5'(k)), c[k]);
    mode = e[70:69]; lvi = 5'(s + 5'd3); smp_take = 1'b1;
    pulse_start(s);
    drain(got_n);
    check($sformatf("v%0d R3/R4 sample total", v), got_n, exp_n);
    check($sformatf("v%0d R5/R6/R7 error flag", v), int'(frm_err), int'(exp_err));
    check($sformatf("v%0d R8 end flag", v), int'(at_end), int'(!exp_err));
    check($sformatf("v%0d R2/R7 final index", v), int'(cur_idx), exp_idx);
  endtask

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: state out of reset
    check("R1 busy after reset", int'(busy), 0);
    check("R1 req after reset", int'(smp_req), 0);
    check("R1 err after reset", int'(frm_err), 0);
    check("R1 idx after reset", int'(cur_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 remain after reset", int'(remain), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R3: remain holds with take low, then drops by one per take
    pulse_chan_rst();
    wr(5'd9, 16'd6);
    mode = 2'd2; lvi = 5'd9; smp_take = 1'b0;
    pulse_start(5'd9);
    repeat (5) @(negedge clk);
    check("R3 remain holds", int'(remain), 6);
    check("R3 req while waiting", int'(smp_req), 1);
    smp_take = 1'b1;
    @(negedge clk); smp_take = 1'b0;
    @(negedge clk);
    check("R3 one take", int'(remain), 5);
    smp_take = 1'b1;
    drain(n);
    check("R3 rest drained", n, 5);
    check("R8 end reached", int'(at_end), 1);

    // R10: start ignored while busy
    pulse_start(5'd0);
    @(negedge clk);
    check("R10 idx unchanged", int'(cur_idx), 9);
    check("R10 still at end", int'(at_end), 1);

    // R9: raising lvi resumes
    wr(5'd10, 16'd12);
    @(negedge clk); lvi = 5'd10;
    @(negedge clk);
    check("R9 end cleared", int'(at_end), 0);
    drain(n);
    check("R9 resumed samples", n, 12);
    check("R9 new end index", int'(cur_idx), 10);
    check("R9 end again", int'(at_end), 1);

    // R7: halt ignores start, chan_rst clears
    pulse_chan_rst();
    wr(5'd3, 16'd5);
    mode = 2'd0; lvi = 5'd3;
    pulse_start(5'd3);
    repeat (2) @(negedge clk);
    check("R6 odd count error", int'(frm_err), 1);
    pulse_start(5'd20);
    repeat (2) @(negedge clk);
    check("R7 err sticky", int'(frm_err), 1);
    check("R7 idx frozen", int'(cur_idx), 3);
    check("R7 no req", int'(smp_req), 0);
    pulse_chan_rst();
    check("R1 chan_rst clears err", int'(frm_err), 0);
    check("R1 chan_rst idle", int'(busy), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule